// File: doc/BRIEF.md
# Accumulator ALU with Flag Update

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator, a second operand already fetched by the datapath, the current flag nibble and a small operation code. From these it produces a result byte, the next flag nibble and a strobe. The strobe tells the register file whether the result replaces the accumulator. Fetching the operand, memory traffic, sequencing and wide arithmetic belong to other blocks.

Operations fall into two classes, picked by `acc_cls`. In the pair class, the accumulator is combined with the operand by one of eight operations: add, add with carry, subtract, subtract with carry, AND, XOR, OR and compare. In the accumulator class, only the accumulator and the flags are used: decimal adjust, one's complement, set carry and invert carry. Every operation has its own rule for each of the four flags. The block applies those rules in full, including the nibble carry and nibble borrow.

Top module: `alu8_core`

## Requirements
- R1: The flag nibble is {Z,N,H,C} on bits 3..0 of `flags_in` and `flags_out`. With `acc_cls`=0, `op_code` values 0..7 select ADD, ADC, SUB, SBC, AND, XOR, OR, CP. With `acc_cls`=1, values 4..7 select DAA, CPL, SCF, CCF.
- R2: ADD and ADC return the low byte of the sum. They set Z when that byte is zero, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7.
- R3: SUB and SBC return accumulator minus operand. They set Z when the byte is zero, set N, set H on a borrow into bit 4 and set C on a borrow out of bit 7.
- R4: ADC and SBC add or subtract the incoming C in the low nibble and in the full byte, so the incoming C affects both H and C.
- R5: AND returns the bitwise AND with Z from the result, N=0, H=1, C=0.
- R6: XOR and OR return their bitwise result with Z from the result and N, H, C all cleared.
- R7: CP produces the flags of SUB, keeps `acc_we` low and drives the unchanged accumulator on `res_out`.
- R8: When N is 0, DAA adds 0x60 if C is set or the accumulator exceeds 0x99. In that case C becomes 1; otherwise C becomes 0. DAA also adds 0x06 if H is set or the low nibble exceeds 9. Z follows the result, H is cleared and N is kept.
- R9: When N is 1, DAA subtracts 0x60 if C is set and 0x06 if H is set. C is kept, H is cleared, N is kept and Z follows the result.
- R10: CPL returns the inverted accumulator and sets N and H. Z and C are left as they came in.
- R11: SCF sets C and CCF inverts C. Both clear N and H, keep Z, keep `acc_we` low and pass the accumulator through.
- R12: Accumulator-class codes 0..3 have no effect: `res_out` equals the accumulator, `flags_out` equals `flags_in` and `acc_we` is low.
- R13: `acc_we` is high for the seven pair operations other than CP, and for DAA and CPL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_cls | input | 1 | 0 = pair operation, 1 = accumulator-only operation |
| op_code | input | 3 | Operation within the selected class |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand for pair operations |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_out | output | 8 | Result byte |
| flags_out | output | 4 | Next flags {Z,N,H,C} |
| acc_we | output | 1 | Result is to be written to the accumulator |

## Verification
Decimal adjust is the hardest case to reach from the ports. Its outcome depends jointly on N, H, C and both accumulator nibbles, and the wrap-around case needs an accumulator above 0x99 with a low nibble above 9. The stimulus therefore places DAA directly after hand-worked BCD additions and subtractions. It also drives the flag combinations that a preceding add or subtract would leave, including the pair of corrections that wraps the byte to zero and sets C. Subtract with carry from zero, with C set, is driven explicitly, because it is the only way to see both borrows come from the incoming carry alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;          // data width
  localparam int NW = DW / 2;     // nibble width for half carry
  localparam int FW = 4;          // flag nibble width
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [2:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_XOR, OP_OR, OP_CP
  } pair_op_e;

  typedef enum logic [2:0] {
    AC_RSV0, AC_RSV1, AC_RSV2, AC_RSV3, AC_DAA, AC_CPL, AC_SCF, AC_CCF
  } acc_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          half,
  output logic          carry
);
  logic [NW:0] lo;
  logic [DW:0] full;

  always_comb begin
    if (!sub) begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    end
  end

  assign res   = full[DW-1:0];
  assign half  = lo[NW];
  assign carry = full[DW];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  pair_op_e      op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      default: res = a | b;
    endcase
  end
endmodule

// File: rtl/alu8_adjust.sv
module alu8_adjust
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          n_in,
  input  logic          h_in,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam logic [NW-1:0] FIX = NW'(6);
  localparam logic [NW-1:0] LIM = NW'(9);
  localparam logic [DW-1:0] HI_LIM = {LIM, LIM};

  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] corr;

  always_comb begin
    if (!n_in) begin
      hi_fix = c_in | (a > HI_LIM);
      lo_fix = h_in | (a[NW-1:0] > LIM);
    end else begin
      hi_fix = c_in;
      lo_fix = h_in;
    end
    corr  = {(hi_fix ? FIX : '0), (lo_fix ? FIX : '0)};
    res   = n_in ? (a - corr) : (a + corr);
    c_out = hi_fix;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          acc_cls,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  input  logic [FW-1:0] flags_in,
  output logic [DW-1:0] res_out,
  output logic [FW-1:0] flags_out,
  output logic          acc_we
);
  pair_op_e      pop;
  acc_op_e       aop;
  logic          as_sub;
  logic          as_cin;
  logic [DW-1:0] as_res;
  logic          as_h;
  logic          as_c;
  logic [DW-1:0] lg_res;
  logic [DW-1:0] da_res;
  logic          da_c;

  assign pop    = pair_op_e'(op_code);
  assign aop    = acc_op_e'(op_code);
  assign as_sub = (pop == OP_SUB) || (pop == OP_SBC) || (pop == OP_CP);
  assign as_cin = ((pop == OP_ADC) || (pop == OP_SBC)) && flags_in[FC];

  alu8_addsub u_addsub (
    .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
    .res(as_res), .half(as_h), .carry(as_c)
  );

  alu8_logic u_logic (
    .op(pop), .a(acc_in), .b(opnd_in), .res(lg_res)
  );

  alu8_adjust u_adjust (
    .a(acc_in), .n_in(flags_in[FN]), .h_in(flags_in[FH]), .c_in(flags_in[FC]),
    .res(da_res), .c_out(da_c)
  );

  always_comb begin
    res_out   = acc_in;
    flags_out = flags_in;
    acc_we    = 1'b0;
    if (!acc_cls) begin
      unique case (pop)
        OP_ADD, OP_ADC: begin
          res_out   = as_res;
          flags_out = {as_res == '0, 1'b0, as_h, as_c};
          acc_we    = 1'b1;
        end
        OP_SUB, OP_SBC: begin
          res_out   = as_res;
          flags_out = {as_res == '0, 1'b1, as_h, as_c};
          acc_we    = 1'b1;
        end
        OP_CP: begin
          flags_out = {as_res == '0, 1'b1, as_h, as_c};
        end
        OP_AND: begin
          res_out   = lg_res;
          flags_out = {lg_res == '0, 1'b0, 1'b1, 1'b0};
          acc_we    = 1'b1;
        end
        default: begin
          res_out   = lg_res;
          flags_out = {lg_res == '0, 3'b000};
          acc_we    = 1'b1;
        end
      endcase
    end else begin
      unique case (aop)
        AC_DAA: begin
          res_out   = da_res;
          flags_out = {da_res == '0, flags_in[FN], 1'b0, da_c};
          acc_we    = 1'b1;
        end
        AC_CPL: begin
          res_out   = ~acc_in;
          flags_out = {flags_in[FZ], 1'b1, 1'b1, flags_in[FC]};
          acc_we    = 1'b1;
        end
        AC_SCF: flags_out = {flags_in[FZ], 1'b0, 1'b0, 1'b1};
        AC_CCF: flags_out = {flags_in[FZ], 1'b0, 1'b0, ~flags_in[FC]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic          acc_cls,
  input logic [2:0]    op_code,
  input logic [DW-1:0] acc_in,
  input logic [DW-1:0] opnd_in,
  input logic [FW-1:0] flags_in,
  input logic [DW-1:0] res_out,
  input logic [FW-1:0] flags_out,
  input logic          acc_we
);
  always_comb begin
    if (!acc_cls && op_code == 3'd7)
      AST_CP_NO_WRITE: assert (!acc_we && res_out == acc_in) else $error("cp wrote"); // R7
    if (!acc_cls && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd7))
      AST_SUB_SETS_N: assert (flags_out[FN]) else $error("N clear on subtract"); // R3
    if (!acc_cls && (op_code == 3'd4 || op_code == 3'd5 || op_code == 3'd6))
      AST_LOGIC_NO_CARRY: assert (!flags_out[FC] && !flags_out[FN]) else $error("logic carry"); // R5
    if (!acc_cls && op_code != 3'd7)
      AST_ZERO_TRACKS: assert (flags_out[FZ] == (res_out == '0)) else $error("Z mismatch"); // R2
    if (acc_cls && op_code == 3'd5)
      AST_CPL_KEEPS_ZC: assert (flags_out[FZ] == flags_in[FZ] && flags_out[FC] == flags_in[FC])
        else $error("cpl touched Z/C"); // R10
    if (acc_cls && !op_code[2])
      AST_RSV_INERT: assert (!acc_we && flags_out == flags_in && res_out == acc_in)
        else $error("reserved code acted"); // R12
    if (acc_cls && op_code == 3'd4)
      AST_DAA_N_KEPT: assert (flags_out[FN] == flags_in[FN] && !flags_out[FH])
        else $error("daa N/H"); // R8
    if (!acc_cls)
      AST_PAIR_WE: assert (acc_we == (op_code != 3'd7)) else $error("pair we"); // R13
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .acc_cls(acc_cls), .op_code(op_code), .acc_in(acc_in), .opnd_in(opnd_in),
  .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .acc_we(acc_we)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk;
  logic       rst_n;
  logic       acc_cls;
  logic [2:0] op_code;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [3:0] flags_in;
  logic [7:0] res_out;
  logic [3:0] flags_out;
  logic       acc_we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu8_core uut (
    .acc_cls(acc_cls), .op_code(op_code), .acc_in(acc_in), .opnd_in(opnd_in),
    .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .acc_we(acc_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step(input string tag, input logic cls, input logic [2:0] code,
                      input logic [7:0] a, input logic [7:0] b, input logic [3:0] f,
                      input logic [7:0] e_res, input logic [3:0] e_fl, input logic e_we);
    @(negedge clk);
    acc_cls = cls; op_code = code; acc_in = a; opnd_in = b; flags_in = f;
    @(posedge clk);
    #1;
    checks++;
    if (res_out !== e_res || flags_out !== e_fl || acc_we !== e_we) begin
      errors++;
      $display("FAIL %s: res=%h exp %h flags=%b exp %b we=%b exp %b",
               tag, res_out, e_res, flags_out, e_fl, acc_we, e_we);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    acc_cls = 1'b0; op_code = 3'd0; acc_in = 8'h00; opnd_in = 8'h00; flags_in = 4'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step("R1 idle add", 0, 0, 8'h00, 8'h00, 4'b0000, 8'h00, 4'b1000, 1);
  endtask

  task automatic t_add;
    step("R2 add wrap",    0, 0, 8'h3A, 8'hC6, 4'b0000, 8'h00, 4'b1011, 1);
    step("R2 add half",    0, 0, 8'h0F, 8'h01, 4'b0001, 8'h10, 4'b0010, 1);
    step("R4 adc cin half",0, 1, 8'hE1, 8'h0F, 4'b0001, 8'hF1, 4'b0010, 1);
    step("R4 adc cin carry",0,1, 8'h80, 8'h80, 4'b0001, 8'h01, 4'b0001, 1);
    step("R4 adc no cin",  0, 1, 8'h80, 8'h80, 4'b0000, 8'h00, 4'b1001, 1);
  endtask

  task automatic t_sub;
    step("R3 sub zero",    0, 2, 8'h3E, 8'h3E, 4'b0000, 8'h00, 4'b1100, 1);
    step("R3 sub half",    0, 2, 8'h3E, 8'h0F, 4'b0000, 8'h2F, 4'b0110, 1);
    step("R3 sub borrow",  0, 2, 8'h10, 8'h20, 4'b0000, 8'hF0, 4'b0101, 1);
    step("R4 sbc cin",     0, 3, 8'h3B, 8'h2A, 4'b0001, 8'h10, 4'b0100, 1);
    step("R4 sbc from 0",  0, 3, 8'h00, 8'h00, 4'b0001, 8'hFF, 4'b0111, 1);
  endtask

  task automatic t_logic;
    step("R5 and",         0, 4, 8'h5A, 8'h3F, 4'b0101, 8'h1A, 4'b0010, 1);
    step("R5 and zero",    0, 4, 8'hF0, 8'h0F, 4'b0000, 8'h00, 4'b1010, 1);
    step("R6 xor zero",    0, 5, 8'hFF, 8'hFF, 4'b0111, 8'h00, 4'b1000, 1);
    step("R6 or",          0, 6, 8'h5A, 8'h00, 4'b1111, 8'h5A, 4'b0000, 1);
  endtask

  task automatic t_cp;
    step("R7 cp half",     0, 7, 8'h3C, 8'h2F, 4'b0000, 8'h3C, 4'b0110, 0);
    step("R7 cp less",     0, 7, 8'h3C, 8'h40, 4'b0000, 8'h3C, 4'b0101, 0);
    step("R7 cp equal",    0, 7, 8'h3C, 8'h3C, 4'b0001, 8'h3C, 4'b1100, 0);
  endtask

  task automatic t_daa;
    step("R8 daa low fix", 1, 4, 8'h7D, 8'h00, 4'b0000, 8'h83, 4'b0000, 1);
    step("R8 daa wrap",    1, 4, 8'h9A, 8'h00, 4'b0000, 8'h00, 4'b1001, 1);
    step("R8 daa h in",    1, 4, 8'h12, 8'h00, 4'b0010, 8'h18, 4'b0000, 1);
    step("R9 daa sub h",   1, 4, 8'h4B, 8'h00, 4'b0110, 8'h45, 4'b0100, 1);
    step("R9 daa sub c",   1, 4, 8'hF0, 8'h00, 4'b0101, 8'h90, 4'b0101, 1);
  endtask

  task automatic t_accops;
    step("R10 cpl keep",   1, 5, 8'h35, 8'h00, 4'b1001, 8'hCA, 4'b1111, 1);
    step("R10 cpl clear",  1, 5, 8'h35, 8'h00, 4'b0000, 8'hCA, 4'b0110, 1);
    step("R11 scf",        1, 6, 8'h77, 8'h00, 4'b1110, 8'h77, 4'b1001, 0);
    step("R11 ccf set",    1, 7, 8'h77, 8'h00, 4'b0111, 8'h77, 4'b0000, 0);
    step("R11 ccf clr",    1, 7, 8'h77, 8'h00, 4'b1100, 8'h77, 4'b1001, 0);
  endtask

  task automatic t_reserved;
    for (int k = 0; k < 4; k++)
      step("R12 reserved", 1, 3'(k), 8'hA5, 8'h5A, 4'b1010, 8'hA5, 4'b1010, 0);
    // R13 write strobe covered by every step above
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: res=%h exp done flags=%b exp - we=%b exp -", res_out, flags_out, acc_we);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cp();
    t_daa();
    t_accops();
    t_reserved();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule